// File: doc/BRIEF.md
# Descriptor List Walker

This block steps one DMA engine, either the transmit or the receive side, through a list of descriptors kept in system memory. Software loads a list base address. A poll pulse then starts the walk. Each descriptor is four 32-bit words: a control word, a word of buffer lengths, a first buffer pointer, and a second pointer. The second pointer is either a second buffer or the address of the next descriptor. The walker reads the words one at a time over a request/grant/response memory port. It hands each non-empty buffer to a downstream data mover and waits for the mover to finish. It then writes the control word back with the ownership flag cleared, and moves to the next descriptor.

Linking is either implicit or explicit. In implicit (ring) mode the next descriptor sits 16 bytes further on, and an end-of-ring flag sends the walk back to the base. In explicit (chained) mode the second pointer is the next descriptor address. A descriptor that software has not handed over, because its ownership flag is clear, parks the walker in a suspended state. The walker leaves that state only on the next poll pulse, and it then re-reads the same descriptor.

Top module: `desc_walker`

## Requirements
- R1: After reset the walker is stopped: rd_req, buf_req and wr_req are low and suspended is low until a poll pulse arrives.
- R2: A base_we pulse while the walker is stopped (after reset or while suspended) loads base_in as both the list base and the current descriptor address. The next word-0 read goes to that address.
- R3: A base_we pulse while the walker is busy with a descriptor is ignored. Neither the current address nor the end-of-ring return address changes.
- R4: A descriptor at address A is read as four single-word reads at A, A+4, A+8 and A+12, in that order, with one read outstanding at a time. rd_req and rd_addr hold until rd_gnt, and the word is taken on rd_valid.
- R5: If bit 31 (ownership) of word 0 is clear, no further word is read. The walker asserts suspended and issues no request until a poll pulse. The poll makes it read word 0 again at the same address.
- R6: Buffer 1 takes its length from word 1 bits [LENW-1:0] and its address from word 2. When the length is non-zero, buf_req is raised with that address and length and held until buf_done. When the length is zero, no request is made.
- R7: Buffer 2 takes its length from word 1 bits [16+LENW-1:16] and its address from word 3. It is requested after buffer 1, only when the chain flag (word 0 bit 24) is clear and the length is non-zero.
- R8: After the buffers, word 0 is written back to address A with bit 31 cleared and every other bit unchanged. This write comes before any read of the next descriptor.
- R9: In ring mode (bit 24 clear) the next descriptor is at A+16. If the end-of-ring flag (word 0 bit 25) is set, the next descriptor is at the base instead.
- R10: In chained mode (bit 24 set) the next descriptor address is word 3. This takes precedence over the end-of-ring flag.
- R11: suspended is high exactly while the walker is parked on a descriptor whose ownership bit was clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_we | input | 1 | Pulse: load base_in as list base |
| base_in | input | AW | New list base address |
| poll | input | 1 | Pulse: start or resume the walk |
| suspended | output | 1 | Parked on a descriptor not owned by the engine |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | AW | Byte address of the word to read |
| rd_gnt | input | 1 | Read request accepted |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Word 0 write-back request |
| wr_addr | output | AW | Write-back address |
| wr_data | output | 32 | Write-back data |
| wr_gnt | input | 1 | Write accepted |
| buf_req | output | 1 | Buffer transfer request to the data mover |
| buf_addr | output | AW | Buffer start address |
| buf_len | output | LENW | Buffer length in bytes |
| buf_done | input | 1 | Data mover finished the buffer |

## Verification
The bench builds the walker with AW=16 and LENW=11. This keeps every descriptor inside a 1 KB memory model and puts the largest buffer length (0x7FF) within easy reach. It also lets word-1 bits above each length field be set to prove they are ignored. With 16-bit pointers, high bits placed in the pointer words are dropped on the way to buf_addr. Grant, response and completion delays vary with the cycle count, so holds under back-pressure are exercised. The bench covers a three-entry ring that wraps to its base, a ring re-run with a base write while busy, a chained pair that links back to itself, and repeated suspension.

// File: rtl/desc_walker.sv
module desc_walker #(
  parameter int AW      = 32,
  parameter int LENW    = 13,
  parameter int OWN_BIT = 31,
  parameter int EOR_BIT = 25,
  parameter int CHN_BIT = 24,
  parameter int B2_LSB  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            base_we,
  input  logic [AW-1:0]   base_in,
  input  logic            poll,
  output logic            suspended,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  input  logic            rd_gnt,
  input  logic            rd_valid,
  input  logic [31:0]     rd_data,
  output logic            wr_req,
  output logic [AW-1:0]   wr_addr,
  output logic [31:0]     wr_data,
  input  logic            wr_gnt,
  output logic            buf_req,
  output logic [AW-1:0]   buf_addr,
  output logic [LENW-1:0] buf_len,
  input  logic            buf_done
);

  localparam logic [AW-1:0] STRIDE = AW'(16);
  localparam logic [31:0]   OWN_MASK = 32'd1 << OWN_BIT;

  typedef enum logic [2:0] {
    ST_STOP, ST_REQ, ST_RSP, ST_BUF1, ST_BUF2, ST_WB, ST_SUSP
  } st_t;

  st_t             st;
  logic [AW-1:0]   base_q, cur_q, p1_q, p2_q;
  logic [LENW-1:0] len1_q, len2_q;
  logic [31:0]     w0_q;
  logic [1:0]      idx;

  logic            stopped, chained, skip1, skip2;
  logic [AW-1:0]   next_addr;

  assign stopped   = (st == ST_STOP) || (st == ST_SUSP);
  assign chained   = w0_q[CHN_BIT];
  assign skip1     = (len1_q == '0);
  assign skip2     = chained || (len2_q == '0);
  assign next_addr = chained ? p2_q : (w0_q[EOR_BIT] ? base_q : cur_q + STRIDE);

  assign suspended = (st == ST_SUSP);
  assign rd_req    = (st == ST_REQ);
  assign rd_addr   = cur_q + {{(AW-4){1'b0}}, idx, 2'b00};
  assign wr_req    = (st == ST_WB);
  assign wr_addr   = cur_q;
  assign wr_data   = w0_q & ~OWN_MASK;
  assign buf_req   = ((st == ST_BUF1) && !skip1) || ((st == ST_BUF2) && !skip2);
  assign buf_addr  = (st == ST_BUF2) ? p2_q : p1_q;
  assign buf_len   = (st == ST_BUF2) ? len2_q : len1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_STOP;
      base_q <= '0;
      cur_q  <= '0;
      p1_q   <= '0;
      p2_q   <= '0;
      len1_q <= '0;
      len2_q <= '0;
      w0_q   <= '0;
      idx    <= '0;
    end else begin
      if (stopped && base_we) begin
        base_q <= base_in;
        cur_q  <= base_in;
      end
      case (st)
        ST_STOP, ST_SUSP: begin
          if (poll) begin
            st  <= ST_REQ;
            idx <= '0;
          end
        end
        ST_REQ: if (rd_gnt) st <= ST_RSP;
        ST_RSP: begin
          if (rd_valid) begin
            case (idx)
              2'd0: w0_q <= rd_data;
              2'd1: begin
                len1_q <= rd_data[LENW-1:0];
                len2_q <= rd_data[B2_LSB +: LENW];
              end
              2'd2: p1_q <= rd_data[AW-1:0];
              default: p2_q <= rd_data[AW-1:0];
            endcase
            if (idx == 2'd0 && !rd_data[OWN_BIT]) begin
              st <= ST_SUSP;
            end else if (idx == 2'd3) begin
              st <= ST_BUF1;
            end else begin
              idx <= idx + 2'd1;
              st  <= ST_REQ;
            end
          end
        end
        ST_BUF1: if (skip1 || buf_done) st <= ST_BUF2;
        ST_BUF2: if (skip2 || buf_done) st <= ST_WB;
        ST_WB: begin
          if (wr_gnt) begin
            cur_q <= next_addr;
            idx   <= '0;
            st    <= ST_REQ;
          end
        end
        default: st <= ST_STOP;
      endcase
    end
  end

endmodule

// File: rtl/desc_walker_chk.sv
module desc_walker_chk #(
  parameter int AW   = 32,
  parameter int LENW = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            poll,
  input logic            suspended,
  input logic            rd_req,
  input logic [AW-1:0]   rd_addr,
  input logic            rd_gnt,
  input logic            rd_valid,
  input logic            rd_own,
  input logic            wr_req,
  input logic [AW-1:0]   wr_addr,
  input logic [31:0]     wr_data,
  input logic            wr_gnt,
  input logic            buf_req,
  input logic [AW-1:0]   buf_addr,
  input logic [LENW-1:0] buf_len,
  input logic            buf_done
);

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_gnt |=> rd_req && $stable(rd_addr)); // R4
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, wr_req, buf_req})); // R4
  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !rd_req && !wr_req && !buf_req); // R5
  AST_SUSP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(rd_valid) && !$past(rd_own)); // R11
  AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && poll |=> rd_req && !suspended); // R5
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    buf_req && !buf_done |=> buf_req && $stable(buf_addr) && $stable(buf_len)); // R6
  AST_BUF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    buf_req |-> buf_len != '0); // R7
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_gnt |=> wr_req && $stable(wr_addr) && $stable(wr_data)); // R8

endmodule

bind desc_walker desc_walker_chk #(.AW(AW), .LENW(LENW)) u_chk (
  .clk(clk), .rst_n(rst_n), .poll(poll), .suspended(suspended),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt), .rd_valid(rd_valid),
  .rd_own(rd_data[OWN_BIT]),
  .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_gnt(wr_gnt),
  .buf_req(buf_req), .buf_addr(buf_addr), .buf_len(buf_len), .buf_done(buf_done)
);

// File: tb/sim_desc_walker.sv
`timescale 1ns/1ps
module sim_desc_walker;
  localparam int AW = 16;
  localparam int LENW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_we = 1'b0;
  logic [AW-1:0] base_in = '0;
  logic poll = 1'b0;
  logic suspended;
  logic rd_req, rd_gnt = 1'b0, rd_valid = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic wr_req, wr_gnt = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;
  logic buf_req, buf_done = 1'b0;
  logic [AW-1:0] buf_addr;
  logic [LENW-1:0] buf_len;

  always #2.5 clk = ~clk;

  desc_walker #(.AW(AW), .LENW(LENW)) u0 (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_in(base_in), .poll(poll),
    .suspended(suspended), .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_gnt(wr_gnt), .buf_req(buf_req), .buf_addr(buf_addr),
    .buf_len(buf_len), .buf_done(buf_done)
  );

  int n_run = 0, n_fail = 0;
  logic [31:0] mem [0:255];

  int exp_kind [$];
  logic [AW-1:0] exp_addr [$];
  logic [31:0] exp_data [$];
  logic [AW-1:0] m_cur = '0, m_base = '0;
  bit m_susp = 0;
  logic [AW-1:0] last_rd = '0, first_rd = '0;
  bit first_armed = 0, seen_340 = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rdm(input logic [AW-1:0] a);
    return mem[a[9:2]];
  endfunction

  task automatic push(input int k, input logic [AW-1:0] a, input logic [31:0] d);
    exp_kind.push_back(k); exp_addr.push_back(a); exp_data.push_back(d);
  endtask

  task automatic model_desc();
    logic [31:0] w0, w1;
    logic [AW-1:0] p1, p2;
    logic [LENW-1:0] l1, l2;
    w0 = rdm(m_cur);
    push(0, m_cur, 0);
    if (!w0[31]) begin
      m_susp = 1;
      return;
    end
    for (int i = 1; i < 4; i++) push(0, m_cur + AW'(4 * i), 0);
    w1 = rdm(m_cur + 4);
    l1 = w1[LENW-1:0];
    l2 = w1[16 +: LENW];
    p1 = rdm(m_cur + 8) & 32'hFFFF;
    p2 = rdm(m_cur + 12) & 32'hFFFF;
    if (l1 != 0) push(1, p1, 32'(l1));
    if (!w0[24] && l2 != 0) push(1, p2, 32'(l2));
    push(2, m_cur, w0 & 32'h7FFF_FFFF);
    if (w0[24]) m_cur = p2;            // R10 chained link wins
    else if (w0[25]) m_cur = m_base;   // R9 end-of-ring wrap
    else m_cur = m_cur + 16;           // R9 ring step
  endtask

  task automatic check_event(input int k, input logic [AW-1:0] a, input logic [31:0] d);
    string tag;
    int ek;
    logic [AW-1:0] ea;
    logic [31:0] ed;
    tag = (k == 0) ? "R4 read" : (k == 1) ? "R6 R7 buffer" : "R8 write-back";
    if (exp_kind.size() == 0) begin
      if (m_susp) begin
        chk(0, "R5 request while suspended", 32'(a), 0);
        return;
      end
      model_desc();
    end
    ek = exp_kind.pop_front(); ea = exp_addr.pop_front(); ed = exp_data.pop_front();
    chk(ek == k, {tag, " kind"}, 32'(k), 32'(ek));
    chk(ea == a, {tag, " address"}, 32'(a), 32'(ea));
    chk(ed == d, {tag, " data"}, d, ed);
  endtask

  // memory, write and data-mover responders, driven at the falling edge
  initial begin
    int cyc = 0, rwait = 0, bwait = 0;
    bit rbusy = 0, bseen = 0;
    logic [AW-1:0] racc = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) continue;
      if (rd_gnt) begin
        rd_gnt = 0;
        check_event(0, racc, 0);
        last_rd = racc;
        if (racc == 16'h340) seen_340 = 1;
        if (first_armed) begin first_rd = racc; first_armed = 0; end
        rbusy = 1; rwait = cyc % 2;
      end else if (rbusy) begin
        if (rd_valid) begin rd_valid = 0; rbusy = 0; end
        else if (rwait == 0) begin rd_valid = 1; rd_data = rdm(racc); end
        else rwait--;
      end else if (rd_req && (cyc % 3 != 2)) begin
        rd_gnt = 1; racc = rd_addr;
      end
      if (wr_gnt) begin
        wr_gnt = 0;
      end else if (wr_req && (cyc % 2 == 0)) begin
        check_event(2, wr_addr, wr_data);
        mem[wr_addr[9:2]] = wr_data;
        wr_gnt = 1;
      end
      if (buf_done) begin
        buf_done = 0; bseen = 0;
      end else if (buf_req) begin
        if (!bseen) begin
          check_event(1, buf_addr, 32'(buf_len));
          bseen = 1; bwait = 1 + cyc % 3;
        end else if (bwait == 0) buf_done = 1;
        else bwait--;
      end
    end
  end

  task automatic do_poll();
    @(negedge clk); poll = 1; m_susp = 0; first_armed = 1;
    @(negedge clk); poll = 0;
    chk(!suspended, "R11 suspended low after poll", 32'(suspended), 0);
  endtask

  task automatic write_base(input logic [AW-1:0] a, input bit stopped);
    @(negedge clk); base_we = 1; base_in = a;
    if (stopped) begin m_base = a; m_cur = a; end
    @(negedge clk); base_we = 0;
  endtask

  task automatic wait_susp(input string req);
    for (int i = 0; i < 3000 && !suspended; i++) @(negedge clk);
    chk(suspended, {req, " R11 suspended"}, 32'(suspended), 1);
    chk(exp_kind.size() == 0, {req, " R5 all expected events seen"}, exp_kind.size(), 0);
    repeat (6) @(negedge clk);
    chk(!rd_req && !wr_req && !buf_req, "R5 quiet while suspended",
        {29'd0, rd_req, wr_req, buf_req}, 0);
  endtask

  task automatic put_desc(input logic [AW-1:0] a, input logic [31:0] w0, w1, w2, w3);
    mem[a[9:2]] = w0; mem[a[9:2] + 1] = w1; mem[a[9:2] + 2] = w2; mem[a[9:2] + 3] = w3;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    // ring at 0x100: noise above each length field, high pointer bits dropped
    put_desc(16'h100, 32'h8000_0A5A, 32'h2021_2040, 32'hFFFF_1234, 32'h0000_2000);
    put_desc(16'h110, 32'h8000_0000, 32'h07FF_0000, 32'h0000_5555, 32'h0000_6000);
    put_desc(16'h120, 32'h8200_0001, 32'h0000_0005, 32'h0000_7000, 32'h0000_7777);
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!rd_req && !wr_req && !buf_req, "R1 no requests after reset",
        {29'd0, rd_req, wr_req, buf_req}, 0);
    chk(!suspended, "R1 suspended low after reset", 32'(suspended), 0);

    write_base(16'h100, 1);
    do_poll();
    wait_susp("R9 ring");
    chk(last_rd == 16'h100, "R9 end-of-ring returns to base", 32'(last_rd), 32'h100);
    chk(first_rd == 16'h100, "R2 first read at loaded base", 32'(first_rd), 32'h100);

    // re-arm ring, base write while busy must be ignored
    mem[16'h100 >> 2] = 32'h8000_0A5A;
    mem[16'h110 >> 2] = 32'h8000_0000;
    mem[16'h120 >> 2] = 32'h8200_0001;
    do_poll();
    repeat (2) @(negedge clk);
    write_base(16'h3F0, 0);
    wait_susp("R3 busy base write");
    chk(last_rd == 16'h100, "R3 ring base unchanged by busy write", 32'(last_rd), 32'h100);

    // chained pair, chain flag beats end-of-ring
    put_desc(16'h200, 32'h8300_0000, 32'h0033_0008, 32'h0000_0800, 32'h0000_0340);
    put_desc(16'h340, 32'h8100_0000, 32'h0009_0000, 32'h0000_0900, 32'h0000_0200);
    write_base(16'h200, 1);
    do_poll();
    wait_susp("R10 chain");
    chk(first_rd == 16'h200, "R2 base write while suspended", 32'(first_rd), 32'h200);
    chk(seen_340, "R10 chained link followed", 32'(seen_340), 1);
    chk(last_rd == 16'h200, "R10 chain back to first", 32'(last_rd), 32'h200);

    // poll with nothing re-armed: re-read word 0 and suspend again
    do_poll();
    wait_susp("R5 re-poll");
    chk(first_rd == 16'h200, "R5 re-poll reads same descriptor", 32'(first_rd), 32'h200);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule